// File: doc/BRIEF.md
# Byte-Synchronous Frame Transmitter with CRC

This block is a character-oriented synchronous serial transmitter. The host loads data characters into a small transmit FIFO and issues a start command. At the next character boundary the block sends one or two programmed SYN characters. It then sends the queued data characters, optionally followed by a 16-bit CRC. After the frame it keeps the line busy with fill characters. Fill is either repeated SYN characters or a steady mark level of all ones. The serial output carries one bit per clock, and each character goes out least significant bit first.

The frame ends in one of two ways, chosen by a mode input. In command mode the host issues an end command, and the frame ends once the FIFO has drained. In count mode the frame ends after a programmed number of data characters. A parity bit can be appended to each data character. SYN and CRC characters never carry parity, and SYN characters never enter the CRC. If the FIFO runs dry in mid-frame, the block pulses an underrun output and inserts SYN characters until more data arrives. An optional clear-to-send input can pause the frame, but only between characters.

Top module: `bsync_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `fifo_full` is 0, and the line stays at 1 while no frame has been requested and idle fill is selected.
- R2: A frame starts only after a `cmd_start` pulse. It begins at a character boundary with the SYN character `cfg_syn`, sent twice when `cfg_dual_syn` is 1. The data characters follow in FIFO order, each sent least significant bit first, one bit per clock.
- R3: With `cfg_par_en` set, each data character is followed by one parity bit, so the character is 9 bits. The parity bit is the XOR of the 8 data bits when `cfg_par_odd` is 0, and its inverse when `cfg_par_odd` is 1. SYN, CRC and fill characters are always 8 bits.
- R4: With `cfg_crc_en` set, two CRC characters follow the last data character. The CRC is a 16-bit register that processes the data bits in line order (least significant bit first) by shifting right. When the outgoing bit 0 XOR the data bit is 1, the shifted value is XORed with 0xA001 (`cfg_crc_ccitt`=0) or 0x8408 (`cfg_crc_ccitt`=1). The register starts each frame at 0x0000, or at 0xFFFF when `cfg_crc_init_ones` is 1. Register bits 15:8 are sent first, then bits 7:0, each least significant bit first. SYN characters never enter the CRC.
- R5: With `cfg_crc_en` clear, the fill character directly follows the last data character.
- R6: With `cfg_cnt_mode`=0, a `cmd_end` pulse given while a frame is pending or running ends the frame once the FIFO is empty, and `busy` returns to 0 afterwards.
- R7: With `cfg_cnt_mode`=1, a frame carries exactly `cfg_byte_cnt` data characters (the value sampled at frame start). Any characters left in the FIFO go out in the next frame.
- R8: Between frames the line carries fill: `cfg_syn` characters when `cfg_fill_syn` is 1, and all ones when it is 0.
- R9: If the FIFO is empty in mid-frame and no end condition holds, a SYN character is sent instead, `underrun` pulses once for each inserted SYN, and the inserted SYN is kept out of the CRC. The frame then continues with the next data written.
- R10: With `cfg_cts_en`=1 and `cts`=0, no frame starts and no further frame character begins. The character already on the line completes, and the line then holds 1 until `cts` returns.
- R11: `fifo_full` is 1 when the FIFO holds DEPTH characters (16 by default), and a write while full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | DW | Data character to enqueue |
| fifo_full | output | 1 | FIFO holds DEPTH characters |
| cmd_start | input | 1 | Start-frame command pulse |
| cmd_end | input | 1 | End-of-message command pulse (command mode) |
| cts | input | 1 | Clear-to-send, active high |
| cfg_syn | input | DW | SYN character value |
| cfg_dual_syn | input | 1 | Send two SYN characters at frame start |
| cfg_par_en | input | 1 | Append parity to data characters |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_crc_en | input | 1 | Append 16-bit CRC |
| cfg_crc_ccitt | input | 1 | CCITT polynomial when 1, CRC-16 when 0 |
| cfg_crc_init_ones | input | 1 | CRC start value 0xFFFF when 1, 0x0000 when 0 |
| cfg_fill_syn | input | 1 | Fill with SYN when 1, with ones when 0 |
| cfg_cnt_mode | input | 1 | End frame on byte count when 1, on command when 0 |
| cfg_byte_cnt | input | CNTW | Data characters per frame in count mode |
| cfg_cts_en | input | 1 | Let `cts` pause transmission |
| txd | output | 1 | Serial data output |
| underrun | output | 1 | One-cycle pulse for each SYN inserted on underrun |
| busy | output | 1 | Frame pending or not yet fully issued |

## Verification
The hardest state to reach from the ports is an underrun in mid-frame, where filler SYN characters appear between data characters and must stay out of the CRC. The stimulus loads only two characters and starts a frame without an end command. It waits long enough for several filler SYN characters, then writes the remaining data and issues the end command. The scoreboard accepts any run of one or more SYNs at that point, requires one underrun pulse for each SYN it saw, and checks a CRC computed over the real data only. A clear-to-send drop in mid-frame is checked in a similar way: the scoreboard skips the mark gap between characters, and any character cut short would fail the comparison.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

  // Sequencer states, one per kind of character being issued
  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,
    ST_SYN2   = 2'd1,
    ST_DATA   = 2'd2,
    ST_CRC_LO = 2'd3
  } tx_state_e;

  // Bit-reversed generator polynomials for right-shifting CRC registers
  localparam logic [15:0] POLY_R16    = 16'hA001;
  localparam logic [15:0] POLY_RCCITT = 16'h8408;

endpackage

// File: rtl/bsync_fifo.sv
module bsync_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  // Storage without reset so a distributed RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> $stable(count)); // R11

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty); // R9

endmodule

// File: rtl/bsync_crc16.sv
module bsync_crc16
  import bsync_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          init_ones,
  input  logic          ccitt,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [15:0]   crc
);

  function automatic logic [15:0] step(input logic [15:0] cur,
                                       input logic [DW-1:0] d,
                                       input logic sel_ccitt);
    logic [15:0] r;
    logic        fb;
    r = cur;
    for (int i = 0; i < DW; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ (sel_ccitt ? POLY_RCCITT : POLY_R16);
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)       crc <= '0;
    else if (init) crc <= init_ones ? 16'hFFFF : 16'h0000;
    else if (upd)  crc <= step(crc, din, ccitt);
  end

  AST_CRC_INIT: assert property (@(posedge clk) disable iff (rst)
    (init && init_ones) |=> (crc == 16'hFFFF)); // R4

endmodule

// File: rtl/bsync_tx_ctrl.sv
module bsync_tx_ctrl
  import bsync_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DW-1:0]   cfg_syn,
  input  logic            cfg_dual_syn,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_crc_en,
  input  logic            cfg_fill_syn,
  input  logic            cfg_cnt_mode,
  input  logic [CNTW-1:0] cfg_byte_cnt,
  input  logic            cfg_cts_en,
  input  logic            cts,
  input  logic            cmd_start,
  input  logic            cmd_end,
  input  logic            fifo_empty,
  input  logic [DW-1:0]   fifo_data,
  output logic            fifo_rd,
  output logic            crc_init,
  output logic            crc_upd,
  input  logic [15:0]     crc_val,
  output logic            txd,
  output logic            underrun,
  output logic            busy
);

  localparam int SW = DW + 1;
  localparam int BW = $clog2(SW + 1);
  localparam logic [BW-1:0] LEN_CHR = BW'(DW);
  localparam logic [BW-1:0] LEN_PAR = BW'(DW + 1);
  localparam logic [BW-1:0] LEN_CRC = BW'(8);

  tx_state_e       st, nst;
  logic [SW-1:0]   sh_q, ld_char;
  logic [BW-1:0]   bit_left, ld_len;
  logic [CNTW-1:0] cnt_q;
  logic            start_pend, end_pend;
  logic            bnd, hold, end_cond, ld;
  logic            take_start, clr_end, cnt_load, cnt_dec, urun;
  logic [SW-1:0]   syn_chr, fill_chr, data_chr;
  logic [BW-1:0]   data_len;

  assign syn_chr  = {1'b0, cfg_syn};
  assign fill_chr = cfg_fill_syn ? syn_chr : '1;
  assign data_chr = {(^fifo_data) ^ cfg_par_odd, fifo_data};
  assign data_len = cfg_par_en ? LEN_PAR : LEN_CHR;
  assign bnd      = (bit_left == '0);
  assign hold     = cfg_cts_en && !cts;
  assign end_cond = cfg_cnt_mode ? (cnt_q == '0) : (end_pend && fifo_empty);
  assign busy     = start_pend || (st != ST_FILL);

  // Next-character selection at each character boundary
  always_comb begin
    nst        = st;
    ld         = 1'b0;
    ld_char    = '1;
    ld_len     = LEN_CHR;
    fifo_rd    = 1'b0;
    crc_init   = 1'b0;
    crc_upd    = 1'b0;
    take_start = 1'b0;
    clr_end    = 1'b0;
    cnt_load   = 1'b0;
    cnt_dec    = 1'b0;
    urun       = 1'b0;
    if (bnd) begin
      case (st)
        ST_FILL: begin
          ld = 1'b1;
          if (start_pend && !hold) begin
            take_start = 1'b1;
            crc_init   = 1'b1;
            cnt_load   = 1'b1;
            ld_char    = syn_chr;
            nst        = cfg_dual_syn ? ST_SYN2 : ST_DATA;
          end else begin
            ld_char = fill_chr;
          end
        end
        ST_SYN2: begin
          if (!hold) begin
            ld      = 1'b1;
            ld_char = syn_chr;
            nst     = ST_DATA;
          end
        end
        ST_DATA: begin
          if (!hold) begin
            ld = 1'b1;
            if (end_cond) begin
              clr_end = 1'b1;
              if (cfg_crc_en) begin
                ld_char = SW'(crc_val[15:8]);
                ld_len  = LEN_CRC;
                nst     = ST_CRC_LO;
              end else begin
                ld_char = fill_chr;
                nst     = ST_FILL;
              end
            end else if (fifo_empty) begin
              ld_char = syn_chr;
              urun    = 1'b1;
            end else begin
              fifo_rd = 1'b1;
              crc_upd = 1'b1;
              cnt_dec = 1'b1;
              ld_char = data_chr;
              ld_len  = data_len;
            end
          end
        end
        default: begin
          if (!hold) begin
            ld      = 1'b1;
            ld_char = SW'(crc_val[7:0]);
            ld_len  = LEN_CRC;
            nst     = ST_FILL;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_FILL;
      sh_q       <= '1;
      bit_left   <= '0;
      txd        <= 1'b1;
      underrun   <= 1'b0;
      start_pend <= 1'b0;
      end_pend   <= 1'b0;
      cnt_q      <= '0;
    end else begin
      st       <= nst;
      underrun <= urun;
      if (ld) begin
        txd      <= ld_char[0];
        sh_q     <= ld_char >> 1;
        bit_left <= ld_len - 1'b1;
      end else if (!bnd) begin
        txd      <= sh_q[0];
        sh_q     <= sh_q >> 1;
        bit_left <= bit_left - 1'b1;
      end else begin
        txd <= 1'b1;
      end
      if (take_start)                start_pend <= 1'b0;
      else if (cmd_start && !busy)   start_pend <= 1'b1;
      if (clr_end)                   end_pend <= 1'b0;
      else if (cmd_end && busy)      end_pend <= 1'b1;
      if (cnt_load)                  cnt_q <= cfg_byte_cnt;
      else if (cnt_dec)              cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_CTS_MARK: assert property (@(posedge clk) disable iff (rst)
    (bnd && hold && st != ST_FILL) |=> (txd == 1'b1 && bit_left == '0)); // R10

  AST_CHAR_WHOLE: assert property (@(posedge clk) disable iff (rst)
    (bit_left != '0) |=> (bit_left == $past(bit_left) - 1'b1)); // R10

  AST_URUN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (st == ST_DATA && !$past(fifo_rd))); // R9

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CRC_LO) |=> $stable(crc_val)); // R4

  AST_NO_START_HELD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FILL && hold) |=> (st == ST_FILL)); // R10

endmodule

// File: rtl/bsync_tx.sv
module bsync_tx #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  parameter int CNTW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic            fifo_full,
  input  logic            cmd_start,
  input  logic            cmd_end,
  input  logic            cts,
  input  logic [DW-1:0]   cfg_syn,
  input  logic            cfg_dual_syn,
  input  logic            cfg_par_en,
  input  logic            cfg_par_odd,
  input  logic            cfg_crc_en,
  input  logic            cfg_crc_ccitt,
  input  logic            cfg_crc_init_ones,
  input  logic            cfg_fill_syn,
  input  logic            cfg_cnt_mode,
  input  logic [CNTW-1:0] cfg_byte_cnt,
  input  logic            cfg_cts_en,
  output logic            txd,
  output logic            underrun,
  output logic            busy
);

  logic          f_rd, f_empty;
  logic [DW-1:0] f_data;
  logic          c_init, c_upd;
  logic [15:0]   c_val;

  bsync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(f_rd), .rd_data(f_data),
    .empty(f_empty), .full(fifo_full)
  );

  bsync_crc16 #(.DW(DW)) u_crc (
    .clk(clk), .rst(rst),
    .init(c_init), .init_ones(cfg_crc_init_ones), .ccitt(cfg_crc_ccitt),
    .upd(c_upd), .din(f_data), .crc(c_val)
  );

  bsync_tx_ctrl #(.DW(DW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst(rst),
    .cfg_syn(cfg_syn), .cfg_dual_syn(cfg_dual_syn),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_crc_en(cfg_crc_en), .cfg_fill_syn(cfg_fill_syn),
    .cfg_cnt_mode(cfg_cnt_mode), .cfg_byte_cnt(cfg_byte_cnt),
    .cfg_cts_en(cfg_cts_en), .cts(cts),
    .cmd_start(cmd_start), .cmd_end(cmd_end),
    .fifo_empty(f_empty), .fifo_data(f_data), .fifo_rd(f_rd),
    .crc_init(c_init), .crc_upd(c_upd), .crc_val(c_val),
    .txd(txd), .underrun(underrun), .busy(busy)
  );

endmodule

// File: tb/bsync_tx_tb.sv
module bsync_tx_tb;
  localparam int DW = 8, DEPTH = 16, CNTW = 8;
  localparam logic [7:0] SYN = 8'h16;

  logic clk = 1'b0, rst = 1'b1;
  always #2.5 clk = ~clk;

  logic wr_en = 0, cmd_start = 0, cmd_end = 0, cts = 1;
  logic [7:0] wr_data = '0;
  logic cfg_dual_syn = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_crc_en = 1;
  logic cfg_crc_ccitt = 0, cfg_crc_init_ones = 0, cfg_fill_syn = 0;
  logic cfg_cnt_mode = 0, cfg_cts_en = 0;
  logic [CNTW-1:0] cfg_byte_cnt = '0;
  logic fifo_full, txd, underrun, busy;

  bsync_tx #(.DW(DW), .DEPTH(DEPTH), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .cmd_start(cmd_start), .cmd_end(cmd_end), .cts(cts), .cfg_syn(SYN),
    .cfg_dual_syn(cfg_dual_syn), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_ccitt(cfg_crc_ccitt),
    .cfg_crc_init_ones(cfg_crc_init_ones), .cfg_fill_syn(cfg_fill_syn),
    .cfg_cnt_mode(cfg_cnt_mode), .cfg_byte_cnt(cfg_byte_cnt), .cfg_cts_en(cfg_cts_en),
    .txd(txd), .underrun(underrun), .busy(busy)
  );

  typedef struct {
    logic [8:0] val;
    int         len;
    bit         wild;
    bit         last;
    string      tag;
  } item_t;

  item_t expq[$];
  int checks = 0, errors = 0, frames_done = 0, wild_syns = 0;
  int urun_pulses = 0, gap_bits = 0, cyc = 0;
  bit in_frame = 0, gap_mode = 0, first_pending = 0;
  logic [7:0] fb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst && underrun) urun_pulses++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b,
                                          input bit ccitt);
    logic [15:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if (r[0] != b[k]) r = (r >> 1) ^ (ccitt ? 16'h8408 : 16'hA001);
      else              r = r >> 1;
    end
    return r;
  endfunction

  task automatic push_item(input logic [8:0] v, input int len, input bit wild,
                           input bit last, input string tag);
    item_t it;
    it.val = v; it.len = len; it.wild = wild; it.last = last; it.tag = tag;
    expq.push_back(it);
  endtask

  // Driver side: expected character stream of one frame plus the fill after it
  task automatic build(input logic [7:0] b[$], input int wild_at, input bit fill_syn,
                       input string tag);
    logic [15:0] c = cfg_crc_init_ones ? 16'hFFFF : 16'h0000;
    push_item({1'b0, SYN}, 8, 0, 0, "R2 syn");
    if (cfg_dual_syn) push_item({1'b0, SYN}, 8, 0, 0, "R2 second syn");
    foreach (b[i]) begin
      if (i == wild_at) push_item('0, 8, 1, 0, "R9 inserted syn");
      if (cfg_par_en) push_item({(^b[i]) ^ cfg_par_odd, b[i]}, 9, 0, 0, {tag, " R3 data"});
      else            push_item({1'b0, b[i]}, 8, 0, 0, {tag, " data"});
      c = ref_crc(c, b[i], cfg_crc_ccitt);
    end
    if (cfg_crc_en) begin
      push_item({1'b0, c[15:8]}, 8, 0, 0, "R4 crc high");
      push_item({1'b0, c[7:0]}, 8, 0, 0, "R4 crc low");
    end
    push_item(fill_syn ? {1'b0, SYN} : 9'h0FF, 8, 0, 1,
              cfg_crc_en ? "R8 fill" : "R5 fill after data");
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk); cmd_end = 1'b1; @(negedge clk); cmd_end = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    wait (frames_done >= n);
    repeat (10) @(negedge clk);
  endtask

  // Monitor side: collect one character from the line
  task automatic get_char(input int len, input bit skip_ok, output logic [8:0] v);
    v = '0;
    for (int i = 0; i < len; i++) begin
      if (first_pending) first_pending = 0;
      else begin
        @(negedge clk);
        if (i == 0 && skip_ok)
          while (txd === 1'b1) begin gap_bits++; @(negedge clk); end
      end
      v[i] = txd;
    end
  endtask

  initial begin
    item_t it;
    logic [8:0] v, pre;
    bit have_pre;
    int n;
    wait (!rst);
    forever begin
      @(negedge clk);
      if (expq.size() != 0 && txd === 1'b0) begin
        in_frame = 1; first_pending = 1; have_pre = 0;
        forever begin
          it = expq.pop_front();
          if (it.wild) begin
            n = 0;
            forever begin
              get_char(8, 0, v);
              if (v[7:0] == SYN) n++;
              else begin pre = v; have_pre = 1; break; end
            end
            wild_syns += n;
            chk(n >= 1, "R9", "inserted syn count", n, 1);
          end else begin
            if (have_pre) begin v = pre; have_pre = 0; end
            else get_char(it.len, gap_mode && !it.val[0], v);
            chk(v == it.val, it.tag, "character", v, it.val);
          end
          if (it.last) break;
        end
        in_frame = 0;
        frames_done++;
      end
    end
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R1", "txd after reset", txd, 1);
    chk(busy === 1'b0, "R1", "busy after reset", busy, 0);
    chk(fifo_full === 1'b0, "R1", "fifo_full after reset", fifo_full, 0);

    // T1: CRC-16, init zero, command mode, idle fill
    fb = '{8'hA5, 8'h3C, 8'h81};
    foreach (fb[i]) wr(fb[i]);
    bad = 0;
    repeat (30) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk(bad == 0, "R2", "line idle without start", bad, 0);
    build(fb, -1, 0, "R6");
    pulse_start(); pulse_end();
    wait_frames(1);
    chk(busy === 1'b0, "R6", "busy after end", busy, 0);

    // T2: dual SYN, even parity, CCITT with init ones
    cfg_dual_syn = 1; cfg_par_en = 1; cfg_crc_ccitt = 1; cfg_crc_init_ones = 1;
    fb = '{8'h07, 8'hFE, 8'h55, 8'h80};
    foreach (fb[i]) wr(fb[i]);
    build(fb, -1, 0, "R3 even");
    pulse_start(); pulse_end();
    wait_frames(2);

    // T3: odd parity, CRC off
    cfg_dual_syn = 0; cfg_par_odd = 1; cfg_crc_en = 0;
    fb = '{8'h00, 8'h13};
    foreach (fb[i]) wr(fb[i]);
    build(fb, -1, 0, "R5 odd");
    pulse_start(); pulse_end();
    wait_frames(3);

    // T4: count mode, leftovers go in the next frame
    cfg_par_en = 0; cfg_par_odd = 0; cfg_crc_en = 1; cfg_crc_ccitt = 0;
    cfg_crc_init_ones = 0; cfg_cnt_mode = 1; cfg_byte_cnt = 3;
    fb = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    foreach (fb[i]) wr(fb[i]);
    fb = '{8'h11, 8'h22, 8'h33};
    build(fb, -1, 0, "R7 first");
    pulse_start();
    wait_frames(4);
    cfg_byte_cnt = 2;
    fb = '{8'h44, 8'h55};
    build(fb, -1, 0, "R7 second");
    pulse_start();
    wait_frames(5);

    // T5: underrun in mid-frame
    cfg_cnt_mode = 0; cfg_dual_syn = 1; cfg_crc_init_ones = 1;
    wr(8'h9A); wr(8'h4C);
    fb = '{8'h9A, 8'h4C, 8'h62, 8'h2E};
    build(fb, 2, 0, "R9");
    urun_pulses = 0; wild_syns = 0;
    pulse_start();
    repeat (60) @(negedge clk);
    wr(8'h62); wr(8'h2E);
    pulse_end();
    wait_frames(6);
    chk(urun_pulses == wild_syns, "R9", "underrun pulses vs inserted syns",
        urun_pulses, wild_syns);

    // T6: clear-to-send holds start and pauses between characters
    cfg_dual_syn = 0; cfg_crc_en = 0; cfg_cts_en = 1; cts = 0;
    fb = '{8'h02, 8'h04, 8'h08};
    foreach (fb[i]) wr(fb[i]);
    build(fb, -1, 0, "R10");
    pulse_start(); pulse_end();
    bad = 0;
    repeat (50) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk(bad == 0, "R10", "no start while cts low", bad, 0);
    chk(busy === 1'b1, "R10", "busy while held", busy, 1);
    gap_mode = 1; gap_bits = 0;
    cts = 1;
    wait (in_frame);
    repeat (12) @(negedge clk);
    cts = 0;
    repeat (30) @(negedge clk);
    cts = 1;
    wait_frames(7);
    chk(gap_bits >= 20, "R10", "mark gap length", gap_bits, 20);
    gap_mode = 0; cfg_cts_en = 0;

    // T7: full FIFO, discarded write, SYN fill after the frame
    cfg_crc_en = 1;
    fb.delete();
    for (int i = 0; i < DEPTH; i++) fb.push_back(8'(i * 13 + 1));
    foreach (fb[i]) wr(fb[i]);
    chk(fifo_full === 1'b1, "R11", "full after DEPTH writes", fifo_full, 1);
    wr(8'hEE);
    build(fb, -1, 1, "R11");
    pulse_start(); pulse_end();
    wait (in_frame);
    cfg_fill_syn = 1;
    wait_frames(8);
    chk(fifo_full === 1'b0, "R11", "full clears after drain", fifo_full, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule